// File: doc/BRIEF.md
# Muxed Double-Divider Gated Peripheral Clock

This block produces one peripheral clock from four slow reference clocks. A select field picks one reference, two cascaded 3-bit divider stages set an overall ratio equal to the product of their codes, and a disable bit gates the result. All logic runs on a fast system clock. The references are sampled, their rising edges become ticks, and the output is a registered level built from those ticks.

Software programs the block through a word-addressed register bank with a combinational read port. The bank holds six words: source select, three divider-select words, a clock-select word and a clock-disable word. Only the source field, the two stage codes of the first divider word and bit 0 of the disable word drive the output. The other words are kept for readback. A new divider code or gate setting is taken up only where an output period starts, so a high phase already in progress is never cut short. To restore saved settings, write the disable word first, then the three divider words in order, then source select, then clock select.

Top module: `periph_clk_gen`

## Requirements
- R1: After reset every register reads 0 and `clk_o` is low.
- R2: Words at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 store all DW bits and read back exactly. The word index is `addr_i[4:2]`. Any other offset, including one with `addr_i[1:0]` not zero, reads 0, and a write to it changes nothing.
- R3: Bits [1:0] of word 0x00 select `ref_i[sel]` as the divided source. The values 0 to 3 map to inputs 0 to 3.
- R4: Stage codes A (bits [2:0] of word 0x04) and B (bits [5:3]) give a ratio N = A*B. The output period is N periods of the selected reference.
- R5: For N > 1 the output is high for ceil(N/2) reference periods of each N. For N = 1 the output follows the level of the selected reference.
- R6: A code of 0 or 7 in either stage holds `clk_o` low once the period in progress ends.
- R7: A divider code change is applied only at the next output period start. The high phase in progress keeps its full length.
- R8: Bit 0 of word 0x14 is a disable: 1 stops `clk_o` and 0 lets it run. The change is applied at a period start, so a high phase in progress completes.
- R9: Words 0x08, 0x0C and 0x10 have no effect on `clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the references |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | NREF | Reference clocks, sampled internally |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Byte address of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Combinational read data |
| clk_o | output | 1 | Divided, gated peripheral clock |

## Verification
The hardest situations to reach from the ports are a register write that lands inside an output high phase. Such a write must not shorten that pulse, whether it changes the divider code or the disable bit. The stimulus waits for a rising edge of `clk_o`, writes one cycle later and then times the falling edge against the old ratio. Random source and code choices drawn from a fixed seed cover the ratio and duty rules across all four references. Directed cases cover invalid codes and the readback-only words.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned REG_N  = 6;

  typedef enum int unsigned {
    IDX_SRC  = 0,
    IDX_DIV0 = 1,
    IDX_DIV1 = 2,
    IDX_DIV2 = 3,
    IDX_CSEL = 4,
    IDX_DIS  = 5
  } reg_idx_e;

  function automatic logic code_ok(input logic [CODE_W-1:0] c);
    return (c != '0) && (c != '1);
  endfunction
endpackage

// File: rtl/pcg_regbank.sv
module pcg_regbank
  import pcg_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned SELW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [SELW-1:0]   src_sel_o,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              dis_o
);
  localparam int unsigned IW = AW - 2;

  logic [DW-1:0] regs_q [REG_N];
  logic [IW-1:0] idx;
  logic          hit;

  assign idx = addr_i[AW-1:2];
  assign hit = (addr_i[1:0] == 2'b00) && (idx < IW'(REG_N));

  for (genvar g = 0; g < REG_N; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wr_en_i && hit && (idx == IW'(g)))    regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o   = hit ? regs_q[idx] : '0;
  assign src_sel_o = regs_q[int'(IDX_SRC)][SELW-1:0];
  assign code_a_o  = regs_q[int'(IDX_DIV0)][CODE_W-1:0];
  assign code_b_o  = regs_q[int'(IDX_DIV0)][2*CODE_W-1:CODE_W];
  assign dis_o     = regs_q[int'(IDX_DIS)][0];

  // R2
  wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit) |=> (regs_q[$past(idx)] == $past(wdata_i)));
endmodule

// File: rtl/pcg_ref_sync.sv
module pcg_ref_sync #(
  parameter int unsigned NREF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREF-1:0] ref_i,
  output logic [NREF-1:0] lvl_o,
  output logic [NREF-1:0] rise_o
);
  for (genvar g = 0; g < NREF; g++) begin : g_ref
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], ref_i[g]};
    end
    assign lvl_o[g]  = sh_q[1];
    assign rise_o[g] = sh_q[1] & ~sh_q[2];
  end
endmodule

// File: rtl/pcg_div_core.sv
module pcg_div_core
  import pcg_pkg::*;
#(
  parameter int unsigned NREF = 4,
  parameter int unsigned SELW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SELW-1:0]   sel_i,
  input  logic [CODE_W-1:0] code_a_i,
  input  logic [CODE_W-1:0] code_b_i,
  input  logic              dis_i,
  input  logic [NREF-1:0]   lvl_i,
  input  logic [NREF-1:0]   rise_i,
  output logic              clk_o
);
  localparam int unsigned NW = 2 * CODE_W;

  logic [NW-1:0] cnt_q, act_n_q, new_n, hi_len;
  logic          act_ok_q, gate_q, clk_q;
  logic          tick, lvl, new_ok, reload;

  assign tick   = rise_i[sel_i];
  assign lvl    = lvl_i[sel_i];
  assign new_ok = code_ok(code_a_i) && code_ok(code_b_i);
  assign new_n  = NW'(code_a_i) * NW'(code_b_i);
  assign hi_len = (act_n_q + NW'(1)) >> 1;
  // period start: last count, or nothing valid loaded yet
  assign reload = !act_ok_q || (cnt_q == act_n_q - NW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      act_n_q  <= '0;
      act_ok_q <= 1'b0;
      gate_q   <= 1'b0;
      clk_q    <= 1'b0;
    end else if (tick && reload) begin
      cnt_q    <= '0;
      act_n_q  <= new_n;
      act_ok_q <= new_ok;
      gate_q   <= !dis_i;
      clk_q    <= new_ok && !dis_i;
    end else if (tick) begin
      cnt_q <= cnt_q + NW'(1);
      clk_q <= gate_q && ((act_n_q == NW'(1)) ? lvl : ((cnt_q + NW'(1)) < hi_len));
    end else if (act_ok_q && (act_n_q == NW'(1))) begin
      clk_q <= gate_q && lvl;
    end
  end

  assign clk_o = clk_q;

  // R6
  invalid_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_ok_q |-> !clk_q);
  // R8
  gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_q |-> !clk_q);
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick && reload) |=> $stable(act_n_q));
  // R5
  no_runt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_q && (act_n_q != NW'(1)) && !tick) |=> clk_q);
  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_ok_q |-> (cnt_q < act_n_q));
endmodule

// File: rtl/periph_clk_gen.sv
module periph_clk_gen
  import pcg_pkg::*;
#(
  parameter int unsigned DW   = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned NREF = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREF-1:0] ref_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            clk_o
);
  localparam int unsigned SELW = $clog2(NREF);

  logic [SELW-1:0]   src_sel;
  logic [CODE_W-1:0] code_a, code_b;
  logic              dis;
  logic [NREF-1:0]   lvl, rise;

  pcg_regbank #(.DW(DW), .AW(AW), .SELW(SELW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .src_sel_o(src_sel), .code_a_o(code_a), .code_b_o(code_b), .dis_o(dis)
  );

  pcg_ref_sync #(.NREF(NREF)) u_sync (
    .clk_i, .rst_ni, .ref_i, .lvl_o(lvl), .rise_o(rise)
  );

  pcg_div_core #(.NREF(NREF), .SELW(SELW)) u_core (
    .clk_i, .rst_ni, .sel_i(src_sel), .code_a_i(code_a), .code_b_i(code_b),
    .dis_i(dis), .lvl_i(lvl), .rise_i(rise), .clk_o
  );
endmodule

// File: tb/tb_periph_clk_gen.sv
module tb_periph_clk_gen;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0]  refc = '0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        clk_out;
  int          cyc = 0, checks = 0, errors = 0;
  int          half [4] = '{4, 6, 8, 5};

  periph_clk_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(refc), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .clk_o(clk_out)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar g = 0; g < 4; g++) begin : g_refgen
    initial begin
      #2;
      forever begin
        #(half[g] * 8);
        refc[g] = ~refc[g];
      end
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog act=%0d exp<=150000", cyc);
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_lvl(input logic v, output int t);
    int n = 0;
    @(negedge clk);
    while (clk_out !== v && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(0, "timeout", n, 0);
    t = cyc;
  endtask

  task automatic measure(output int hi, output int per);
    int t0, t1, t2;
    wait_lvl(0, t0); wait_lvl(1, t0); wait_lvl(0, t1); wait_lvl(1, t2);
    hi = t1 - t0; per = t2 - t0;
  endtask

  function automatic int exp_per(input int n, input int s);
    return n * 2 * half[s];
  endfunction

  function automatic int exp_hi(input int n, input int s);
    return (n == 1) ? half[s] : ((n + 1) / 2) * 2 * half[s];
  endfunction

  task automatic cfg(input int s, input int a, input int b);
    wr(5'h00, 32'(s));
    wr(5'h04, 32'((b << 3) | a));
    repeat (3 * 36 * 16 + 40) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] vals [6];
    int hi, per, t0, t1, s, a, b, n, lowcnt;
    void'($urandom(32'd1234));

    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(5'(i * 4), d);
      chk(d == 0, "R1 reset read", d, 0);
    end
    lowcnt = 0;
    repeat (200) begin @(negedge clk); if (clk_out) lowcnt++; end
    chk(lowcnt == 0, "R1 clk_o low", lowcnt, 0);

    // R2 readback
    for (int i = 0; i < 6; i++) begin
      vals[i] = $urandom;
      wr(5'(i * 4), vals[i]);
    end
    wr(5'h18, 32'hdead_beef);
    wr(5'h05, 32'hffff_ffff);
    for (int i = 0; i < 6; i++) begin
      rd(5'(i * 4), d);
      chk(d == vals[i], "R2 readback", d, vals[i]);
    end
    rd(5'h18, d); chk(d == 0, "R2 unmapped read", d, 0);
    rd(5'h05, d); chk(d == 0, "R2 misaligned read", d, 0);
    rd(5'h04, d); chk(d == vals[1], "R2 misaligned write ignored", d, vals[1]);

    // restore order: disable, dividers, source, clock select
    wr(5'h14, 32'h1); wr(5'h04, 0); wr(5'h08, 0); wr(5'h0C, 0);
    wr(5'h00, 0); wr(5'h10, 0); wr(5'h14, 32'h0);

    // R1 R3 R4 R5 directed corners
    cfg(0, 1, 1);
    measure(hi, per);
    chk(per == exp_per(1, 0), "R4 N=1 period", per, exp_per(1, 0));
    chk(hi == exp_hi(1, 0), "R5 N=1 follows ref", hi, exp_hi(1, 0));
    cfg(2, 6, 6);
    measure(hi, per);
    chk(per == exp_per(36, 2), "R4 N=36 period", per, exp_per(36, 2));
    chk(hi == exp_hi(36, 2), "R5 N=36 high", hi, exp_hi(36, 2));

    // R3 R4 R5 random
    for (int k = 0; k < 10; k++) begin
      s = $urandom_range(0, 3); a = $urandom_range(1, 6); b = $urandom_range(1, 6);
      n = a * b;
      cfg(s, a, b);
      measure(hi, per);
      chk(per == exp_per(n, s), "R3/R4 period", per, exp_per(n, s));
      chk(hi == exp_hi(n, s), "R5 high phase", hi, exp_hi(n, s));
    end

    // R9 extra words have no effect
    cfg(3, 3, 1);
    wr(5'h08, $urandom); wr(5'h0C, $urandom); wr(5'h10, $urandom);
    measure(hi, per);
    chk(per == exp_per(3, 3), "R9 period unchanged", per, exp_per(3, 3));
    chk(hi == exp_hi(3, 3), "R9 high unchanged", hi, exp_hi(3, 3));

    // R6 invalid codes
    cfg(1, 7, 2);
    lowcnt = 0;
    repeat (600) begin @(negedge clk); if (clk_out) lowcnt++; end
    chk(lowcnt == 0, "R6 code 7 low", lowcnt, 0);
    cfg(0, 3, 0);
    lowcnt = 0;
    repeat (600) begin @(negedge clk); if (clk_out) lowcnt++; end
    chk(lowcnt == 0, "R6 code 0 low", lowcnt, 0);

    // R7 change during high phase
    cfg(2, 5, 1);
    wait_lvl(0, t0); wait_lvl(1, t0);
    wr(5'h04, 32'((1 << 3) | 2));
    wait_lvl(0, t1);
    chk(t1 - t0 == exp_hi(5, 2), "R7 old high kept", t1 - t0, exp_hi(5, 2));
    measure(hi, per);
    chk(per == exp_per(2, 2), "R7 new period", per, exp_per(2, 2));
    chk(hi == exp_hi(2, 2), "R7 new high", hi, exp_hi(2, 2));

    // R8 disable during high phase
    cfg(1, 3, 1);
    wait_lvl(0, t0); wait_lvl(1, t0);
    wr(5'h14, 32'h1);
    wait_lvl(0, t1);
    chk(t1 - t0 == exp_hi(3, 1), "R8 high completes", t1 - t0, exp_hi(3, 1));
    lowcnt = 0;
    repeat (400) begin @(negedge clk); if (clk_out) lowcnt++; end
    chk(lowcnt == 0, "R8 disabled low", lowcnt, 0);
    repeat ($urandom_range(1, 30)) @(negedge clk);
    wr(5'h14, 32'h0);
    measure(hi, per);
    chk(per == exp_per(3, 1), "R8 re-enable period", per, exp_per(3, 1));
    chk(hi == exp_hi(3, 1), "R8 re-enable high", hi, exp_hi(3, 1));

    finish_run();
  end
endmodule